// File: doc/BRIEF.md
# Write-Once Nonvolatile Memory Timing Divider

This block derives the slow timing strobe that paces erase and program sequencing of on-chip nonvolatile memory from the bus clock. Software configures it through one 8-bit register on a simple CPU bus. The register has an address match, a write strobe and registered read data. The low seven bits hold a prescale select and a divisor. They lock after the first write following reset. The top bit is a read-only flag that shows whether that write has happened.

The divided rate is the bus rate divided by (N+1), or by 8*(N+1) when the prescaler is selected. The output is a one-bus-cycle strobe at that rate, not a gated clock. The sequencer downstream counts whole strobes to time its pulses. An enable output goes high with the loaded flag and permits erase and program. Until the register is written, both counters are held at zero and no strobe appears.

Top module: `nvclk_divider`

## Requirements
- R1: After reset the register reads 0x00, `pgm_en` is 0 and `tick` is 0.
- R2: The first write to `REG_ADDR` after reset stores `bus_wdata[6:0]` and sets the loaded flag in the same clock edge, whatever the data. Bit 6 is the prescale select and bits 5:0 are the divisor N.
- R3: Once the loaded flag is set, further writes change neither the stored bits nor the divider until the next reset.
- R4: A write to any other address neither sets the flag nor stores data.
- R5: While `bus_addr` equals `REG_ADDR`, `bus_rdata` shows {flag, select, N} (flag in bit 7) one cycle later. Other addresses read 0x00. Reads have no side effects.
- R6: `pgm_en` equals the loaded flag.
- R7: `tick` stays 0 while the loaded flag is 0.
- R8: With select 0, `tick` is first high N+1 cycles after the loading edge and then repeats every N+1 cycles.
- R9: With select 1, `tick` is first high 8*(N+1) cycles after the loading edge and then repeats every 8*(N+1) cycles.
- R10: When the period is greater than one cycle, `tick` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DIV_W+1 | Writable bits: select then divisor |
| bus_rdata | output | DIV_W+2 | Registered read data |
| tick | output | 1 | One-cycle strobe at the divided rate |
| pgm_en | output | 1 | Erase/program permitted |

## Verification
The bench builds the block with its defaults: a 6-bit divisor, a divide-by-8 prescaler and a 16-bit address. With these values the whole divisor range is reachable, from a period of one cycle up to 512 cycles (N=63 with the prescaler). The vectors therefore cover both ends of the divisor, both prescale settings and the two example operating points. The directed tests cover locking, foreign addresses and the silent state before loading.

// File: rtl/nvclk_pkg.sv
package nvclk_pkg;
  parameter int unsigned NV_DIV_W     = 6;
  parameter int unsigned NV_PRE_RATIO = 8;
  parameter int unsigned NV_ADDR_W    = 16;

  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_DIVIDE = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/nvclk_cfg_reg.sv
module nvclk_cfg_reg
  import nvclk_pkg::*;
#(
  parameter int unsigned ADDR_W   = NV_ADDR_W,
  parameter int unsigned DIV_W    = NV_DIV_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DIV_W:0]    bus_wdata,
  output logic [DIV_W+1:0]  bus_rdata,
  output logic              loaded,
  output pre_mode_e         pre_mode,
  output logic [DIV_W-1:0]  div_val
);
  logic hit;
  logic first_wr;

  assign hit      = (bus_addr == REG_ADDR);
  assign first_wr = hit && bus_wr && !loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded   <= 1'b0;
      pre_mode <= PRE_BYPASS;
      div_val  <= '0;
    end else if (first_wr) begin
      loaded   <= 1'b1;
      pre_mode <= pre_mode_e'(bus_wdata[DIV_W]);
      div_val  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (hit) begin
      bus_rdata <= {loaded, pre_mode, div_val};
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/nvclk_prescale.sv
module nvclk_prescale
  import nvclk_pkg::*;
#(
  parameter int unsigned RATIO = NV_PRE_RATIO
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  pre_mode_e mode,
  output logic      step
);
  generate
    if (RATIO <= 1) begin : g_none
      assign step = run;
    end else begin : g_count
      localparam int unsigned PW = $clog2(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] pcnt;
      logic          wrap;

      assign wrap = (pcnt == LAST);
      assign step = run && ((mode == PRE_BYPASS) || wrap);

      always_ff @(posedge clk) begin
        if (rst || !run || (mode == PRE_BYPASS)) begin
          pcnt <= '0;
        end else if (wrap) begin
          pcnt <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/nvclk_divcount.sv
module nvclk_divcount #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= step && at_end;
      if (step) begin
        cnt <= at_end ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvclk_divider.sv
module nvclk_divider
  import nvclk_pkg::*;
#(
  parameter int unsigned ADDR_W    = NV_ADDR_W,
  parameter int unsigned DIV_W     = NV_DIV_W,
  parameter int unsigned PRE_RATIO = NV_PRE_RATIO,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(16'h0040)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DIV_W:0]    bus_wdata,
  output logic [DIV_W+1:0]  bus_rdata,
  output logic              tick,
  output logic              pgm_en
);
  logic             loaded;
  pre_mode_e        pre_mode;
  logic [DIV_W-1:0] div_val;
  logic             pre_step;

  nvclk_cfg_reg #(
    .ADDR_W  (ADDR_W),
    .DIV_W   (DIV_W),
    .REG_ADDR(REG_ADDR)
  ) i_cfg (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .loaded   (loaded),
    .pre_mode (pre_mode),
    .div_val  (div_val)
  );

  nvclk_prescale #(
    .RATIO(PRE_RATIO)
  ) i_pre (
    .clk (clk),
    .rst (rst),
    .run (loaded),
    .mode(pre_mode),
    .step(pre_step)
  );

  nvclk_divcount #(
    .DIV_W(DIV_W)
  ) i_div (
    .clk  (clk),
    .rst  (rst),
    .run  (loaded),
    .step (pre_step),
    .limit(div_val),
    .tick (tick)
  );

  assign pgm_en = loaded;
endmodule

// File: rtl/nvclk_divider_chk.sv
module nvclk_divider_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DIV_W  = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              tick,
  input logic              pgm_en,
  input logic              sel,
  input logic [DIV_W-1:0]  div
);
  AST_FLAG_SET_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR && !pgm_en) |=> pgm_en); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    pgm_en |=> pgm_en); // R6

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    pgm_en |=> ($stable(sel) && $stable(div))); // R3

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != REG_ADDR && !pgm_en) |=> !pgm_en); // R4

  AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (rst)
    !pgm_en |-> !tick); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tick && (sel || div != '0)) |=> !tick); // R10
endmodule

bind nvclk_divider nvclk_divider_chk #(
  .ADDR_W  (ADDR_W),
  .DIV_W   (DIV_W),
  .REG_ADDR(REG_ADDR)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_addr(bus_addr),
  .bus_wr  (bus_wr),
  .tick    (tick),
  .pgm_en  (pgm_en),
  .sel     (pre_mode),
  .div     (div_val)
);

// File: tb/test_nvclk_divider.sv
`timescale 1ns/1ps
module test_nvclk_divider;
  localparam logic [15:0] RA = 16'h0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        tick;
  logic        pgm_en;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  nvclk_divider i_nvclk_divider (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .pgm_en(pgm_en)
  );

  // {select, N, expected period}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 6'd0,  10'd1},
    {1'b0, 6'd4,  10'd5},
    {1'b0, 6'd49, 10'd50},
    {1'b0, 6'd63, 10'd64},
    {1'b1, 6'd0,  10'd8},
    {1'b1, 6'd12, 10'd104},
    {1'b1, 6'd63, 10'd512}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0; bus_addr = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [6:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_addr = '0;
  endtask

  // Called right after do_write: counts from the loading edge.
  task automatic measure(input string req, input int per);
    int first = 0, last = 0, cnt = 0;
    for (int k = 1; k <= 2 * per; k++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first == 0) first = k;
        last = k;
      end
    end
    chk({req, " first tick"}, first, per);
    chk({req, " tick count"}, cnt, 2);
    chk({req, " second tick"}, last, 2 * per);
  endtask

  task automatic gap(input string req, input int per);
    int k = 0, g = 0;
    while (!tick && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk); g = 1;
    while (!tick && g < 2000) begin @(negedge clk); g++; end
    chk({req, " tick spacing"}, g, per);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int tk;

    // R1 reset state and R7 silence before loading
    do_reset();
    chk("R1 pgm_en", int'(pgm_en), 0);
    do_read(RA, rd);
    chk("R1 read", int'(rd), 0);
    tk = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (tick) tk++; end
    chk("R7 ticks while unloaded", tk, 0);

    // R4 foreign address write
    do_write(16'h0041, 7'h45);
    chk("R4 pgm_en", int'(pgm_en), 0);
    do_read(RA, rd);
    chk("R4 read", int'(rd), 0);
    do_read(16'h0041, rd);
    chk("R5 foreign read", int'(rd), 0);

    // Vector walk: R2, R5, R6, R8, R9, R10
    for (int v = 0; v < NV; v++) begin
      do_reset();
      chk("R1 read after reset", int'(bus_rdata), 0);
      do_write(RA, VEC[v][16:10]);
      chk("R6 pgm_en after load", int'(pgm_en), 1);
      measure(VEC[v][16] ? "R9" : "R8", int'(VEC[v][9:0]));
      do_read(RA, rd);
      chk("R2 R5 readback", int'(rd), int'({1'b1, VEC[v][16:10]}));
    end

    // R3 later writes ignored, reads harmless
    do_reset();
    do_write(RA, 7'h03);
    measure("R8 N=3", 4);
    do_write(RA, 7'h45);
    do_read(RA, rd);
    chk("R3 readback", int'(rd), 8'h83);
    do_read(RA, rd);
    chk("R5 repeated read", int'(rd), 8'h83);
    gap("R3 period kept", 4);
    chk("R6 pgm_en held", int'(pgm_en), 1);

    // R10 single-cycle pulse with prescaler
    do_reset();
    do_write(RA, 7'h41);
    tk = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); if (tick) tk++; end
    chk("R10 R9 ticks in 64 cycles", tk, 4);

    // R1 reset clears a loaded register
    do_reset();
    chk("R1 pgm_en after reload reset", int'(pgm_en), 0);
    chk("R1 tick after reset", int'(tick), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule